// File: doc/BRIEF.md
# Bitwise Identifier Arbitration Monitor

This block sits between a node's serial transmit path and a shared wired-AND bus. Logic 0 is the dominant level and logic 1 is the recessive level. While the identifier field of a frame goes out, the block compares each bit it sends with the bit it reads back from the bus, and it does so on a sample strobe placed inside the bit time. The strobe position absorbs the delay from transmit to receive.

Suppose the node sends recessive but the bus reads back dominant. The node has then lost arbitration. The block latches an arbitration-lost flag and forces its bus drive recessive until the next frame starts.

Comparison happens only when three conditions hold together: the node is in its normal operating mode, the controller marks the identifier window, and fewer than `ID_BITS` identifier bits have been compared since the last frame-start pulse. Arbitration between whole bytes or frames belongs to the surrounding controller.

All pins are plain level or pulse signals with no valid/ready handshake. The bit stream has no back-pressure, because the bus timing paces it.

Top module: `bitarb_monitor`

## Requirements
- R1: After reset `arb_lost` is 0 and `id_open` is 0 until a `frame_start` pulse arrives, and `bus_drive` follows `tx_bit`.
- R2: While `arb_lost` is 0, `bus_drive` equals `tx_bit` in the same cycle.
- R3: A strobed comparison with `tx_bit`=1 (recessive) and `rx_bit`=0 (dominant) sets `arb_lost` from the next cycle, and from then on `bus_drive` is 1 whatever `tx_bit` is.
- R4: A strobed comparison with `tx_bit`=0 and `rx_bit`=1 does not set `arb_lost`.
- R5: While `normal_mode` is 0, no comparison takes place and a mismatch leaves `arb_lost` at 0.
- R6: While `id_window` is 0, no comparison takes place and a mismatch leaves `arb_lost` at 0.
- R7: Only the first `ID_BITS` (default 8) comparison strobes after `frame_start` are compared. After the last of them, `id_open` is 0 and a later mismatch is ignored.
- R8: `arb_lost` stays 1 until a `frame_start` pulse, and from the cycle after that pulse it is 0.
- R9: When `frame_start` and a mismatching strobe arrive in the same cycle, the frame start wins. `arb_lost` is 0 afterwards, and that strobe does not count toward the `ID_BITS` identifier bits.
- R10: Strobes that arrive while `id_open` is 0 do not advance the identifier bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| normal_mode | input | 1 | 1 when the node is in its normal operating mode |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| id_window | input | 1 | 1 while the identifier field is on the bus |
| sample_stb | input | 1 | Bit-sample strobe, one pulse per bit |
| tx_bit | input | 1 | Bit the node wants to drive (0 dominant) |
| rx_bit | input | 1 | Bit sampled back from the bus |
| bus_drive | output | 1 | Gated drive toward the bus transmitter |
| arb_lost | output | 1 | 1 once arbitration is lost in the current frame |
| id_open | output | 1 | 1 while a strobe would be compared |

## Verification
A frame-start pulse and a mismatching sample strobe can land in the same clock cycle, and they pull the loss flag and the bit counter in opposite directions. The bench first makes the node lose arbitration. It then raises `frame_start` together with a recessive-sent, dominant-read strobe. The result is judged in two steps: `arb_lost` must read 0 after that edge, and a mismatch placed exactly on the eighth later strobe must still be caught. That second step proves the colliding strobe was neither compared nor counted.

// File: rtl/bitarb_pkg.sv
package bitarb_pkg;
  typedef enum logic {
    LVL_DOMINANT  = 1'b0,
    LVL_RECESSIVE = 1'b1
  } bus_level_e;

  function automatic logic lost_bit(input logic sent, input logic seen);
    return (sent == LVL_RECESSIVE) && (seen == LVL_DOMINANT);
  endfunction
endpackage

// File: rtl/bitarb_counter.sv
module bitarb_counter #(
  parameter int ID_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic advance,
  output logic room
);
  localparam int CW = $clog2(ID_BITS + 1);
  localparam logic [CW-1:0] LAST = CW'(ID_BITS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= LAST;
    else if (restart)
      cnt_q <= '0;
    else if (advance && (cnt_q != LAST))
      cnt_q <= cnt_q + 1'b1;
  end

  assign room = (cnt_q != LAST);
endmodule

// File: rtl/bitarb_judge.sv
module bitarb_judge
  import bitarb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic compare,
  input  logic sent,
  input  logic seen,
  output logic lost
);
  logic lost_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      lost_q <= 1'b0;
    else if (restart)
      lost_q <= 1'b0;
    else if (compare && lost_bit(sent, seen))
      lost_q <= 1'b1;
  end

  assign lost = lost_q;
endmodule

// File: rtl/bitarb_gate.sv
module bitarb_gate
  import bitarb_pkg::*;
(
  input  logic lost,
  input  logic sent,
  output logic drive
);
  always_comb begin
    if (lost) drive = LVL_RECESSIVE;
    else      drive = sent;
  end
endmodule

// File: rtl/bitarb_monitor.sv
module bitarb_monitor #(
  parameter int ID_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic normal_mode,
  input  logic frame_start,
  input  logic id_window,
  input  logic sample_stb,
  input  logic tx_bit,
  input  logic rx_bit,
  output logic bus_drive,
  output logic arb_lost,
  output logic id_open
);
  logic room;
  logic cmp_en;

  assign id_open = normal_mode && id_window && room;
  assign cmp_en  = sample_stb && id_open && !frame_start;

  bitarb_counter #(.ID_BITS(ID_BITS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .restart(frame_start),
    .advance(cmp_en), .room(room)
  );

  bitarb_judge u_judge (
    .clk(clk), .rst_n(rst_n), .restart(frame_start),
    .compare(cmp_en), .sent(tx_bit), .seen(rx_bit), .lost(arb_lost)
  );

  bitarb_gate u_gate (
    .lost(arb_lost), .sent(tx_bit), .drive(bus_drive)
  );
endmodule

// File: rtl/bitarb_monitor_chk.sv
module bitarb_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic normal_mode,
  input logic frame_start,
  input logic id_window,
  input logic sample_stb,
  input logic tx_bit,
  input logic rx_bit,
  input logic bus_drive,
  input logic arb_lost,
  input logic id_open
);
  p_follow_tx_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !arb_lost |-> bus_drive == tx_bit);

  p_recessive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> bus_drive);

  p_rise_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !arb_lost ##1 arb_lost |-> $past(sample_stb && normal_mode && id_window
                                     && tx_bit && !rx_bit && !frame_start));

  p_no_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !normal_mode && !arb_lost |=> !arb_lost);

  p_no_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !id_window && !arb_lost |=> !arb_lost);

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost && !frame_start |=> arb_lost);

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !arb_lost);

  p_open_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    id_open |-> normal_mode && id_window);
endmodule

bind bitarb_monitor bitarb_monitor_chk u_chk (.*);

// File: tb/bitarb_monitor_test.sv
`timescale 1ns/1ps
module bitarb_monitor_test;
  logic clk = 0, rst_n = 0;
  logic normal_mode = 1, frame_start = 0, id_window = 1, sample_stb = 0;
  logic tx_bit = 0, rx_bit = 0;
  logic bus_drive, arb_lost, id_open;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  bitarb_monitor #(.ID_BITS(8)) uut (.*);

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(input logic tx, input logic rx, input logic stb,
                      input logic fs, input logic nm, input logic win);
    @(negedge clk);
    tx_bit = tx; rx_bit = rx; sample_stb = stb; frame_start = fs;
    normal_mode = nm; id_window = win;
    @(posedge clk); #1;
    sample_stb = 0; frame_start = 0;
  endtask

  task automatic start_frame();
    step(1, 1, 0, 1, 1, 1);
  endtask

  task automatic t_reset();
    #1;
    check("R1 lost at reset", arb_lost, 0);
    check("R1 open at reset", id_open, 0);
    tx_bit = 0; #1;
    check("R1 drive follows tx", bus_drive, 0);
  endtask

  task automatic t_follow();
    start_frame();
    for (int i = 0; i < 8; i++) begin
      step(i[0], i[0], 1, 0, 1, 1);
      check("R2 drive follows tx", bus_drive, i[0]);
    end
    check("R2 no loss on match", arb_lost, 0);
    check("R7 window closed after 8", id_open, 0);
  endtask

  task automatic t_lose();
    start_frame();
    step(0, 0, 1, 0, 1, 1);
    step(1, 1, 1, 0, 1, 1);
    step(1, 0, 1, 0, 1, 1);
    check("R3 loss flagged", arb_lost, 1);
    step(0, 0, 0, 0, 1, 1);
    check("R3 drive recessive", bus_drive, 1);
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    check("R8 loss sticky", arb_lost, 1);
    start_frame();
    check("R8 cleared by frame start", arb_lost, 0);
  endtask

  task automatic t_dom_rec();
    start_frame();
    step(0, 1, 1, 0, 1, 1);
    check("R4 sent dominant no loss", arb_lost, 0);
  endtask

  task automatic t_modes();
    start_frame();
    step(1, 0, 1, 0, 0, 1);
    check("R5 ignored outside normal mode", arb_lost, 0);
    step(1, 0, 1, 0, 1, 0);
    check("R6 ignored outside window", arb_lost, 0);
  endtask

  task automatic t_ninth();
    start_frame();
    for (int i = 0; i < 8; i++) step(1, 1, 1, 0, 1, 1);
    step(1, 0, 1, 0, 1, 1);
    check("R7 ninth strobe ignored", arb_lost, 0);
  endtask

  task automatic t_skip();
    start_frame();
    for (int i = 0; i < 3; i++) step(1, 0, 1, 0, 0, 1);
    for (int i = 0; i < 7; i++) step(1, 1, 1, 0, 1, 1);
    check("R10 window still open", id_open, 1);
    step(1, 0, 1, 0, 1, 1);
    check("R10 eighth counted strobe compared", arb_lost, 1);
  endtask

  task automatic t_collide();
    start_frame();
    step(1, 0, 1, 0, 1, 1);
    check("R9 setup loss", arb_lost, 1);
    step(1, 0, 1, 1, 1, 1);
    check("R9 start wins over mismatch", arb_lost, 0);
    for (int i = 0; i < 7; i++) step(0, 0, 1, 0, 1, 1);
    step(1, 0, 1, 0, 1, 1);
    check("R9 colliding strobe not counted", arb_lost, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1; t_reset();
    @(negedge clk); rst_n = 1;
    t_reset();
    t_follow();
    t_lose();
    t_dom_rec();
    t_modes();
    t_ninth();
    t_skip();
    t_collide();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule